// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of virtual-page to physical-frame translations. Every entry carries, beside its page number and frame number, the identifier of the address space that owns it. A lookup presents a page number and the current identifier and receives a hit flag and the frame number combinationally, in the same cycle. Translations of several processes can be resident together: a page number that matches but belongs to another identifier is simply a miss.

On a miss, an external table walker returns the translation and presents it on the fill port; the block writes it into the lowest-numbered free entry, or, when every entry is valid, over the least recently used one. A fill for a page and identifier pair that is already resident overwrites that entry's frame number. Two maintenance inputs remove translations in one cycle: a global flush, and an invalidate that removes only the entries of one identifier.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses with `lk_hit`=0 and `lk_pfn`=0.
- R2: A lookup with `lk_valid`=1 whose page number and identifier both equal those of a valid entry returns `lk_hit`=1 and that entry's frame number on `lk_pfn` in the same cycle.
- R3: A valid entry whose page number matches but whose identifier differs does not hit; entries of different identifiers with the same page number are resident together and each returns its own frame number.
- R4: A fill accepted at a clock edge (fill_valid=1, no flush, no invalidate) makes a lookup of that pair hit from the next cycle on with the filled frame number.
- R5: While any entry is invalid, a fill of a new pair goes into the lowest-numbered invalid entry and evicts nothing.
- R6: When all entries are valid, a fill of a new pair replaces the entry least recently used as of the start of that cycle; a lookup hit and an accepted fill each make their entry the most recently used, the lookup hit counting before the fill of the same cycle.
- R7: A fill of a pair that is already resident overwrites the frame number of that entry in place; no two valid entries ever hold the same pair.
- R8: `flush_all`=1 invalidates every entry at the next edge; a fill in the same cycle is dropped.
- R9: `inval_en`=1 invalidates exactly the entries whose identifier equals `inval_asid` at the next edge, leaving others intact; a fill in the same cycle is dropped.
- R10: With `lk_valid`=0, `lk_hit` and `lk_pfn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address space identifier of the lookup |
| lk_hit | output | 1 | Lookup found a matching valid entry |
| lk_pfn | output | PFN_W | Frame number of the hit entry, 0 on a miss |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | VPN_W | Page number of the installed translation |
| fill_asid | input | ASID_W | Identifier of the installed translation |
| fill_pfn | input | PFN_W | Frame number of the installed translation |
| flush_all | input | 1 | Invalidate every entry |
| inval_en | input | 1 | Invalidate the entries of one identifier |
| inval_asid | input | ASID_W | Identifier whose entries are invalidated |

## Verification
The bench drives a four-entry configuration with a small pool of page numbers and identifiers, so identical page numbers under different identifiers, refills of a resident pair and full-cache evictions all happen often; a design that ignored the identifier would return another process's frame, and one that appended instead of updating would leave a stale duplicate and evict a live entry early. Eviction order is checked against a timestamp model, which catches a victim taken from the wrong end of the age order or a lookup hit that fails to refresh its entry. Flush and invalidate are issued together with a fill to catch a fill that slips through maintenance, and the invalidate is checked to spare the other identifiers' entries. A fill with free slots is checked not to displace any resident translation.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // How a fill request is placed into the array.
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_FREE   = 2'd2,
    FILL_EVICT  = 2'd3
  } fill_kind_e;

endpackage

// File: rtl/tlb_tag_match.sv
// Per-entry comparator. In pair mode an entry matches on page number and
// identifier; in identifier-only mode the page number is masked out.
module tlb_tag_match #(
  parameter int N         = 8,
  parameter int VPN_W     = 20,
  parameter int ASID_W    = 8,
  parameter bit CHECK_VPN = 1'b1
) (
  input  logic                       req_en,
  input  logic [VPN_W-1:0]           req_vpn,
  input  logic [ASID_W-1:0]          req_asid,
  input  logic [N-1:0]               ent_v,
  input  logic [N-1:0][VPN_W-1:0]    ent_vpn,
  input  logic [N-1:0][ASID_W-1:0]   ent_asid,
  output logic [N-1:0]               match
);

  localparam logic MASK_VPN = !CHECK_VPN;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic vpn_eq;
    logic asid_eq;
    assign vpn_eq   = (ent_vpn[i] == req_vpn);
    assign asid_eq  = (ent_asid[i] == req_asid);
    assign match[i] = req_en & ent_v[i] & asid_eq & (vpn_eq | MASK_VPN);
  end

endmodule

// File: rtl/tlb_lru_ages.sv
// True LRU by age rank: each entry holds a rank 0 (newest) .. N-1 (oldest),
// the ranks always form a permutation. A touch moves one entry to rank 0
// and ages every entry that was younger than it.
module tlb_lru_ages #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      touch_a_en,
  input  logic [IDX_W-1:0]          touch_a_idx,
  input  logic                      touch_b_en,
  input  logic [IDX_W-1:0]          touch_b_idx,
  output logic [N-1:0][IDX_W-1:0]   ages,
  output logic [IDX_W-1:0]          lru_idx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic [N-1:0][IDX_W-1:0] age_q;
  logic [N-1:0][IDX_W-1:0] age_d;

  function automatic logic [N-1:0][IDX_W-1:0] promote(
    input logic [N-1:0][IDX_W-1:0] cur,
    input logic [IDX_W-1:0]        idx
  );
    logic [N-1:0][IDX_W-1:0] res;
    logic [IDX_W-1:0]        pivot;
    pivot = cur[idx];
    for (int i = 0; i < N; i++) begin
      if (IDX_W'(i) == idx)       res[i] = '0;
      else if (cur[i] < pivot)    res[i] = cur[i] + 1'b1;
      else                        res[i] = cur[i];
    end
    return res;
  endfunction

  always_comb begin
    age_d = age_q;
    if (touch_a_en) age_d = promote(age_d, touch_a_idx);
    if (touch_b_en) age_d = promote(age_d, touch_b_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else begin
      age_q <= age_d;
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == OLDEST) lru_idx = IDX_W'(i);
    end
  end

  assign ages = age_q;

endmodule

// File: rtl/tlb_fill_pick.sv
// Chooses the slot for a fill: the resident copy of the pair, else the
// lowest-numbered invalid entry, else the least recently used entry.
module tlb_fill_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic                     fill_en,
  input  logic [N-1:0]             ent_v,
  input  logic [N-1:0]             pair_match,
  input  logic [IDX_W-1:0]         lru_idx,
  output logic [IDX_W-1:0]         slot_idx,
  output tlb_pkg::fill_kind_e      slot_kind
);
  import tlb_pkg::*;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [N-1:0] free_vec;
  assign free_vec = ~ent_v;

  always_comb begin
    slot_idx  = lru_idx;
    slot_kind = FILL_NONE;
    if (fill_en) begin
      if (|pair_match) begin
        slot_idx  = lowest_set(pair_match);
        slot_kind = FILL_UPDATE;
      end else if (|free_vec) begin
        slot_idx  = lowest_set(free_vec);
        slot_kind = FILL_FREE;
      end else begin
        slot_idx  = lru_idx;
        slot_kind = FILL_EVICT;
      end
    end
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              flush_all,
  input  logic              inval_en,
  input  logic [ASID_W-1:0] inval_asid
);
  import tlb_pkg::*;

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  // Entry storage
  logic [N-1:0]             ent_v;
  logic [N-1:0][VPN_W-1:0]  ent_vpn;
  logic [N-1:0][ASID_W-1:0] ent_asid;
  logic [N-1:0][PFN_W-1:0]  ent_pfn;

  // Named internal events
  logic [N-1:0]             lk_match;
  logic [N-1:0]             fill_match;
  logic [N-1:0]             kill_match;
  logic [IDX_W-1:0]         lk_idx;
  logic                     maint;
  logic                     fill_do;
  logic [IDX_W-1:0]         fill_idx;
  fill_kind_e               fill_kind;
  logic [IDX_W-1:0]         lru_idx;
  logic [N-1:0][IDX_W-1:0]  ages;

  tlb_tag_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .CHECK_VPN(1'b1)) u_lk_cmp (
    .req_en  (lk_valid),
    .req_vpn (lk_vpn),
    .req_asid(lk_asid),
    .ent_v   (ent_v),
    .ent_vpn (ent_vpn),
    .ent_asid(ent_asid),
    .match   (lk_match)
  );

  tlb_tag_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .CHECK_VPN(1'b1)) u_fill_cmp (
    .req_en  (fill_valid),
    .req_vpn (fill_vpn),
    .req_asid(fill_asid),
    .ent_v   (ent_v),
    .ent_vpn (ent_vpn),
    .ent_asid(ent_asid),
    .match   (fill_match)
  );

  tlb_tag_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .CHECK_VPN(1'b0)) u_kill_cmp (
    .req_en  (inval_en),
    .req_vpn (fill_vpn),
    .req_asid(inval_asid),
    .ent_v   (ent_v),
    .ent_vpn (ent_vpn),
    .ent_asid(ent_asid),
    .match   (kill_match)
  );

  // Encoder for the (at most one-hot) lookup match vector.
  function automatic logic [IDX_W-1:0] encode(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  assign lk_idx = encode(lk_match);
  assign lk_hit = |lk_match;

  // AND-OR read mux keyed by the match vector: zero on a miss.
  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < N; i++) begin
      lk_pfn = lk_pfn | (ent_pfn[i] & {PFN_W{lk_match[i]}});
    end
  end

  assign maint   = flush_all | inval_en;
  assign fill_do = fill_valid & ~maint;

  tlb_fill_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .fill_en   (fill_do),
    .ent_v     (ent_v),
    .pair_match(fill_match),
    .lru_idx   (lru_idx),
    .slot_idx  (fill_idx),
    .slot_kind (fill_kind)
  );

  tlb_lru_ages #(.N(N), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_a_en (lk_hit),
    .touch_a_idx(lk_idx),
    .touch_b_en (fill_do),
    .touch_b_idx(fill_idx),
    .ages       (ages),
    .lru_idx    (lru_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v    <= '0;
      ent_vpn  <= '0;
      ent_asid <= '0;
      ent_pfn  <= '0;
    end else if (flush_all) begin
      ent_v <= '0;
    end else if (inval_en) begin
      ent_v <= ent_v & ~kill_match;
    end else if (fill_do) begin
      ent_v[fill_idx]    <= 1'b1;
      ent_vpn[fill_idx]  <= fill_vpn;
      ent_asid[fill_idx] <= fill_asid;
      ent_pfn[fill_idx]  <= fill_pfn;
    end
  end

endmodule

// File: rtl/tlb_checks.sv
module tlb_checks #(
  parameter int N      = 8,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int IDX_W  = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lk_valid,
  input logic                      lk_hit,
  input logic [PFN_W-1:0]          lk_pfn,
  input logic                      flush_all,
  input logic                      inval_en,
  input logic [ASID_W-1:0]         inval_asid,
  input logic [N-1:0]              ent_v,
  input logic [N-1:0][ASID_W-1:0]  ent_asid,
  input logic [N-1:0]              lk_match,
  input logic                      fill_do,
  input logic [IDX_W-1:0]          fill_idx,
  input tlb_pkg::fill_kind_e       fill_kind,
  input logic [N-1:0][IDX_W-1:0]   ages
);
  import tlb_pkg::*;

  logic              kill_seen_q;
  logic [ASID_W-1:0] kill_asid_q;
  logic              stale_left;
  logic [N-1:0]      rank_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kill_seen_q <= 1'b0;
      kill_asid_q <= '0;
    end else begin
      kill_seen_q <= inval_en & ~flush_all;
      kill_asid_q <= inval_asid;
    end
  end

  always_comb begin
    stale_left = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ent_v[i] && ent_asid[i] == kill_asid_q) stale_left = 1'b1;
    end
  end

  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < N; i++) rank_seen[ages[i]] = 1'b1;
  end

  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_fill_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_do |=> ent_v[$past(fill_idx)]);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (ent_v == '0));

  assert_inval_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill_seen_q |-> !stale_left);

  assert_evict_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_kind == FILL_EVICT) |-> (ent_v == '1));

  assert_ranks_permute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rank_seen) == N);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && lk_pfn == '0));

endmodule

bind asid_tlb tlb_checks #(.N(N), .PFN_W(PFN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_hit    (lk_hit),
  .lk_pfn    (lk_pfn),
  .flush_all (flush_all),
  .inval_en  (inval_en),
  .inval_asid(inval_asid),
  .ent_v     (ent_v),
  .ent_asid  (ent_asid),
  .lk_match  (lk_match),
  .fill_do   (fill_do),
  .fill_idx  (fill_idx),
  .fill_kind (fill_kind),
  .ages      (ages)
);

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;
  localparam int N  = 4;
  localparam int VW = 8;
  localparam int PW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic          lk_hit;
  logic [PW-1:0] lk_pfn;
  logic          fill_valid = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic          flush_all = 1'b0;
  logic          inval_en = 1'b0;
  logic [AW-1:0] inval_asid = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  asid_tlb #(.N(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
    .flush_all(flush_all), .inval_en(inval_en), .inval_asid(inval_asid)
  );

  // Reference model: recency kept as timestamps (larger = newer).
  bit            mv   [N];
  logic [VW-1:0] mvpn [N];
  logic [AW-1:0] masid[N];
  logic [PW-1:0] mpfn [N];
  int            mst  [N];
  int            now;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      mv[i] = 0; mvpn[i] = '0; masid[i] = '0; mpfn[i] = '0;
      mst[i] = N - 1 - i;
    end
    now = N;
  endtask

  task automatic model_find(input logic [VW-1:0] v, input logic [AW-1:0] a,
                            output bit h, output int idx);
    h = 0; idx = 0;
    for (int i = 0; i < N; i++)
      if (mv[i] && mvpn[i] == v && masid[i] == a) begin h = 1; idx = i; end
  endtask

  function automatic int model_slot(input logic [VW-1:0] v, input logic [AW-1:0] a);
    int oldest;
    for (int i = 0; i < N; i++)
      if (mv[i] && mvpn[i] == v && masid[i] == a) return i;
    for (int i = 0; i < N; i++)
      if (!mv[i]) return i;
    oldest = 0;
    for (int i = 1; i < N; i++)
      if (mst[i] < mst[oldest]) oldest = i;
    return oldest;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive, compare the same-cycle lookup result, advance model.
  task automatic op(input bit lv, input int lvpn, input int lasid,
                    input bit fv, input int fvpn, input int fasid, input int fpfn,
                    input bit fl, input bit iv, input int iasid, input string req);
    bit h; int idx; int slot; logic [PW-1:0] exp_pfn;
    @(negedge clk);
    lk_valid = lv; lk_vpn = VW'(lvpn); lk_asid = AW'(lasid);
    fill_valid = fv; fill_vpn = VW'(fvpn); fill_asid = AW'(fasid); fill_pfn = PW'(fpfn);
    flush_all = fl; inval_en = iv; inval_asid = AW'(iasid);
    #2;
    h = 0; idx = 0;
    if (lv) model_find(VW'(lvpn), AW'(lasid), h, idx);
    exp_pfn = h ? mpfn[idx] : '0;
    check(lk_hit == h, req, lk_hit, h);
    check(lk_pfn == exp_pfn, req, lk_pfn, exp_pfn);
    slot = model_slot(VW'(fvpn), AW'(fasid));
    if (h) begin now++; mst[idx] = now; end
    if (fl) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
    end else if (iv) begin
      for (int i = 0; i < N; i++) if (masid[i] == AW'(iasid)) mv[i] = 0;
    end else if (fv) begin
      mv[slot] = 1; mvpn[slot] = VW'(fvpn); masid[slot] = AW'(fasid); mpfn[slot] = PW'(fpfn);
      now++; mst[slot] = now;
    end
  endtask

  task automatic look(input int v, input int a, input string req);
    op(1, v, a, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic fill(input int v, input int a, input int p, input string req);
    op(0, 0, 0, 1, v, a, p, 0, 0, 0, req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty after reset; R10: idle lookup quiet
    look(8'h01, 0, "R1");
    look(8'h10, 1, "R1");
    op(0, 8'h10, 1, 0, 0, 0, 0, 0, 0, 0, "R10");

    // R2 / R4: fill then hit
    fill(8'h10, 1, 8'hA1, "R4");
    look(8'h10, 1, "R2");
    // R3: same page, other identifier
    look(8'h10, 2, "R3");
    fill(8'h10, 2, 8'hB2, "R3");
    look(8'h10, 1, "R3");
    look(8'h10, 2, "R3");
    op(0, 8'h10, 1, 0, 0, 0, 0, 0, 0, 0, "R10");

    // R7: in-place update, then fill to full and confirm nothing lost
    fill(8'h10, 1, 8'hC3, "R7");
    look(8'h10, 1, "R7");
    fill(8'h20, 1, 8'h24, "R7");
    fill(8'h30, 1, 8'h35, "R7");
    look(8'h10, 1, "R7");
    look(8'h10, 2, "R7");
    look(8'h20, 1, "R7");
    look(8'h30, 1, "R7");

    // R6: full, victim is LRU; refresh one then evict
    look(8'h10, 2, "R6");
    fill(8'h40, 1, 8'h46, "R6");
    look(8'h10, 1, "R6");
    look(8'h10, 2, "R6");
    look(8'h20, 1, "R6");
    look(8'h30, 1, "R6");
    look(8'h40, 1, "R6");
    // lookup hit and fill in the same cycle
    op(1, 8'h30, 1, 1, 8'h50, 3, 8'h57, 0, 0, 0, "R6");
    for (int v = 1; v <= 5; v++) begin
      look(v * 16, 1, "R6");
      look(v * 16, 3, "R6");
    end

    // R8: flush drops a same-cycle fill
    op(0, 0, 0, 1, 8'h60, 1, 8'h61, 1, 0, 0, "R8");
    look(8'h60, 1, "R8");
    look(8'h40, 1, "R8");
    look(8'h50, 3, "R8");

    // R9: invalidate one identifier, fill in same cycle dropped
    fill(8'h01, 1, 8'h11, "R9");
    fill(8'h02, 2, 8'h22, "R9");
    fill(8'h03, 1, 8'h33, "R9");
    fill(8'h04, 3, 8'h44, "R9");
    op(0, 0, 0, 1, 8'h05, 1, 8'h55, 0, 1, 1, "R9");
    look(8'h01, 1, "R9");
    look(8'h03, 1, "R9");
    look(8'h05, 1, "R9");
    look(8'h02, 2, "R9");
    look(8'h04, 3, "R9");

    // R5: two free slots, fills must not displace residents
    fill(8'h06, 3, 8'h66, "R5");
    fill(8'h07, 3, 8'h77, "R5");
    look(8'h02, 2, "R5");
    look(8'h04, 3, "R5");
    look(8'h06, 3, "R5");
    look(8'h07, 3, "R5");

    // Sweep over a small key pool: miss triggers a fill; periodic maintenance
    for (int it = 0; it < 3000; it++) begin
      int v; int a; bit h; int idx;
      v = $urandom_range(0, 5);
      a = $urandom_range(0, 2);
      if (it % 97 == 96) begin
        op(1, v, a, 1, v, a, it & 255, 1, 0, 0, "R8");
      end else if (it % 23 == 22) begin
        op(1, v, a, 1, v, a, it & 255, 0, 1, $urandom_range(0, 2), "R9");
      end else begin
        model_find(VW'(v), AW'(a), h, idx);
        if (!h || (it % 11 == 0))
          op(1, v, a, 1, v, a, (v * 7 + a * 13 + it) & 255, 0, 0, 0, "R6");
        else
          op(1, v, a, 0, 0, 0, 0, 0, 0, 0, "R2");
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule